// File: doc/BRIEF.md
# Flash Command Controller

This block is the command decoder and status logic of a byte-wide NOR flash device, placed behind a synchronous bus. The bus has a chip enable, a write strobe, a read strobe, an address and a data byte. A bus write is any cycle with chip enable and write strobe both high. The block decodes one-cycle and two-cycle command sequences. It starts a modelled write state machine that stays busy for a fixed number of cycles, and it chooses what a bus read returns: array data, the status byte or an identifier code. The storage array lives outside the block. The controller reads it through a combinational address/data pair and changes it through one-cycle write and block-erase pulses.

The address space is split into 2^BLK_W equal blocks, selected by the top BLK_W address bits. With the defaults that is 16 blocks of 64 KB. A block erase can be suspended and later resumed. While it is suspended, array reads of the other blocks are served, and only a small set of commands is taken. The error flags are sticky, so a run of operations can be checked once at the end. The `ready` pin mirrors the state machine so that software need not poll.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset `ready` is 1, reads return array data, and after command 70h the status byte reads 80h.
- R2: A read cycle (ce=1, oe=1) returns its byte in the same cycle. `rdata` is 00h whenever ce or oe is low. In array mode it returns `mem_rdata` for `mem_addr`=`addr`.
- R3: After command 90h, a read with addr[0]=0 returns 89h and a read with addr[0]=1 returns A2h.
- R4: Command 40h or 10h followed by a write of address/data starts a byte write. `ready` is low for exactly WRITE_CYCLES cycles, and `mem_wr_en` pulses once with that address and data in the last busy cycle. Reads then return status until FFh is written.
- R5: Command 20h followed by D0h starts a block erase. `ready` is low for exactly ERASE_CYCLES cycles, and `mem_erase_en` pulses once with `mem_op_addr` inside the addressed block.
- R6: If an erase setup is followed by anything other than D0h, no erase starts. Status bits 5 and 4 are set, and reads return status (B0h).
- R7: A write of B0h during an erase suspends it. From the next cycle `ready` is 1, status reads C0h (bit 7 ready, bit 6 suspended), and the erase does not complete while suspended.
- R8: While suspended, only FFh, 70h and D0h are accepted, and other codes such as 90h have no effect. Array reads of other blocks return data, and reads of the suspended block return 00h.
- R9: D0h while suspended resumes the erase. The busy cycles before and after the suspension add up to exactly ERASE_CYCLES.
- R10: Status bits 5 (erase error), 4 (write error) and 3 (low programming voltage) stay set through later successful operations. They are cleared only by command 50h.
- R11: If `vpp_low` is 1 when a write or erase would start, nothing starts and `ready` stays 1. Status bit 3 is set, together with bit 4 (write, giving 98h) or bit 5 (erase, giving A8h).
- R12: While a byte write is busy, every command except 70h is ignored, including B0h. The busy length is unchanged and reads keep returning status.
- R13: A B0h that arrives in the last busy cycle of an erase is ignored. The erase completes and status bit 6 stays 0 (status 80h).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce | input | 1 | Chip enable |
| we | input | 1 | Write strobe, a bus write when ce is also high |
| oe | input | 1 | Read strobe, a bus read when ce is also high |
| addr | input | ADDR_W | Bus address |
| wdata | input | 8 | Command or data byte |
| vpp_low | input | 1 | Programming voltage below limit |
| rdata | output | 8 | Read data |
| ready | output | 1 | 1 when the state machine is not running |
| mem_addr | output | ADDR_W | Array read address |
| mem_rdata | input | 8 | Array read data |
| mem_wr_en | output | 1 | One-cycle byte program pulse |
| mem_erase_en | output | 1 | One-cycle block erase pulse |
| mem_op_addr | output | ADDR_W | Address of the program or erase |
| mem_op_data | output | 8 | Byte to program |

## Verification
Two functions can land in the same cycle: a suspend request and the final countdown cycle of an erase. The bench provokes this by counting exactly ERASE_CYCLES-1 cycles after the confirm and then writing B0h, so the request reaches the last busy edge. It then checks that the erase pulse occurred, that `ready` returned high and that the status byte reads 80h rather than C0h. A second collision, a status or suspend command written while a byte write is counting, is judged by checking that the measured busy length is unchanged.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

   typedef enum logic [1:0] {
      RM_ARRAY,
      RM_STATUS,
      RM_IDENT
   } rd_mode_e;

   typedef enum logic [1:0] {
      CS_IDLE,
      CS_WSETUP,
      CS_ESETUP
   } cmd_state_e;

   typedef enum logic [1:0] {
      OP_NONE,
      OP_WRITE,
      OP_ERASE
   } wsm_op_e;

   typedef struct packed {
      logic err_erase;
      logic err_write;
      logic err_vpp;
   } sticky_t;

   localparam logic [7:0] CMD_READ_ARRAY = 8'hFF;
   localparam logic [7:0] CMD_IDENT      = 8'h90;
   localparam logic [7:0] CMD_STATUS     = 8'h70;
   localparam logic [7:0] CMD_CLEAR      = 8'h50;
   localparam logic [7:0] CMD_WRITE_A    = 8'h40;
   localparam logic [7:0] CMD_WRITE_B    = 8'h10;
   localparam logic [7:0] CMD_ERASE      = 8'h20;
   localparam logic [7:0] CMD_CONFIRM    = 8'hD0;
   localparam logic [7:0] CMD_SUSPEND    = 8'hB0;

   localparam logic [7:0] ID_MAKER  = 8'h89;
   localparam logic [7:0] ID_DEVICE = 8'hA2;

endpackage

// File: rtl/flash_wsm.sv
module flash_wsm
   import flash_cmd_pkg::*;
#(
   parameter int ADDR_W       = 20,
   parameter int WRITE_CYCLES = 6,
   parameter int ERASE_CYCLES = 24,
   parameter bit SUSPEND_EN   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_wr,
   input  logic              start_er,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic [7:0]        start_data,
   input  logic              suspend_req,
   input  logic              resume_req,
   output logic              running,
   output logic              suspended,
   output logic              erasing,
   output logic              done_wr,
   output logic              done_er,
   output logic [ADDR_W-1:0] op_addr,
   output logic [7:0]        op_data
);

   localparam int MAX_CYC = (WRITE_CYCLES > ERASE_CYCLES) ? WRITE_CYCLES : ERASE_CYCLES;
   localparam int CNT_W   = $clog2(MAX_CYC + 1);

   wsm_op_e          op_q;
   logic [CNT_W-1:0] rem_q;
   logic             susp_q;
   logic             active;
   logic             last;

   assign active  = (op_q != OP_NONE);
   assign running = active && !susp_q;
   assign last    = running && (rem_q == CNT_W'(1));
   assign erasing = (op_q == OP_ERASE);
   assign done_wr = last && (op_q == OP_WRITE);
   assign done_er = last && (op_q == OP_ERASE);
   assign suspended = susp_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         op_q    <= OP_NONE;
         rem_q   <= '0;
         op_addr <= '0;
         op_data <= '0;
      end else if (!active && (start_wr || start_er)) begin
         op_q    <= start_er ? OP_ERASE : OP_WRITE;
         rem_q   <= start_er ? CNT_W'(ERASE_CYCLES) : CNT_W'(WRITE_CYCLES);
         op_addr <= start_addr;
         op_data <= start_data;
      end else if (running) begin
         if (last) begin
            op_q <= OP_NONE;
         end else begin
            rem_q <= rem_q - CNT_W'(1);
         end
      end
   end

   generate
      if (SUSPEND_EN) begin : g_susp
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               susp_q <= 1'b0;
            end else if (suspend_req && running && erasing && !last) begin
               susp_q <= 1'b1;
            end else if (resume_req && susp_q) begin
               susp_q <= 1'b0;
            end
         end
      end else begin : g_nosusp
         logic unused_req;
         assign unused_req = suspend_req | resume_req;
         assign susp_q = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
   import flash_cmd_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bus_wr,
   input  logic [7:0] wdata,
   input  logic       vpp_low,
   input  logic       running,
   input  logic       suspended,
   input  logic       erasing,
   output rd_mode_e   mode,
   output sticky_t    sticky,
   output logic       start_wr,
   output logic       start_er,
   output logic       suspend_req,
   output logic       resume_req
);

   cmd_state_e cstate_q, cstate_n;
   rd_mode_e   mode_q, mode_n;
   sticky_t    sticky_q, sticky_n;

   always_comb begin
      cstate_n    = cstate_q;
      mode_n      = mode_q;
      sticky_n    = sticky_q;
      start_wr    = 1'b0;
      start_er    = 1'b0;
      suspend_req = 1'b0;
      resume_req  = 1'b0;
      if (bus_wr) begin
         unique case (cstate_q)
            CS_WSETUP: begin
               cstate_n = CS_IDLE;
               mode_n   = RM_STATUS;
               if (vpp_low) begin
                  sticky_n.err_vpp   = 1'b1;
                  sticky_n.err_write = 1'b1;
               end else begin
                  start_wr = 1'b1;
               end
            end
            CS_ESETUP: begin
               cstate_n = CS_IDLE;
               mode_n   = RM_STATUS;
               if (wdata != CMD_CONFIRM) begin
                  sticky_n.err_erase = 1'b1;
                  sticky_n.err_write = 1'b1;
               end else if (vpp_low) begin
                  sticky_n.err_vpp   = 1'b1;
                  sticky_n.err_erase = 1'b1;
               end else begin
                  start_er = 1'b1;
               end
            end
            default: begin
               if (running) begin
                  if (wdata == CMD_STATUS) begin
                     mode_n = RM_STATUS;
                  end else if (wdata == CMD_SUSPEND && erasing) begin
                     suspend_req = 1'b1;
                     mode_n      = RM_STATUS;
                  end
               end else if (suspended) begin
                  case (wdata)
                     CMD_READ_ARRAY: mode_n = RM_ARRAY;
                     CMD_STATUS:     mode_n = RM_STATUS;
                     CMD_CONFIRM: begin
                        resume_req = 1'b1;
                        mode_n     = RM_STATUS;
                     end
                     default: ;
                  endcase
               end else begin
                  case (wdata)
                     CMD_READ_ARRAY: mode_n = RM_ARRAY;
                     CMD_IDENT:      mode_n = RM_IDENT;
                     CMD_STATUS:     mode_n = RM_STATUS;
                     CMD_CLEAR:      sticky_n = '0;
                     CMD_WRITE_A, CMD_WRITE_B: begin
                        cstate_n = CS_WSETUP;
                        mode_n   = RM_STATUS;
                     end
                     CMD_ERASE: begin
                        cstate_n = CS_ESETUP;
                        mode_n   = RM_STATUS;
                     end
                     default: ;
                  endcase
               end
            end
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cstate_q <= CS_IDLE;
         mode_q   <= RM_ARRAY;
         sticky_q <= '0;
      end else begin
         cstate_q <= cstate_n;
         mode_q   <= mode_n;
         sticky_q <= sticky_n;
      end
   end

   assign mode   = mode_q;
   assign sticky = sticky_q;

endmodule

// File: rtl/flash_read_mux.sv
module flash_read_mux
   import flash_cmd_pkg::*;
#(
   parameter int BLK_W = 4
) (
   input  logic             rd_en,
   input  rd_mode_e         mode,
   input  logic [BLK_W-1:0] blk,
   input  logic             addr_lsb,
   input  logic [7:0]       mem_rdata,
   input  logic [7:0]       status,
   input  logic             suspended,
   input  logic [BLK_W-1:0] susp_blk,
   output logic [7:0]       rdata
);

   logic blocked;
   assign blocked = suspended && (blk == susp_blk);

   always_comb begin
      rdata = 8'h00;
      if (rd_en) begin
         unique case (mode)
            RM_STATUS: rdata = status;
            RM_IDENT:  rdata = addr_lsb ? ID_DEVICE : ID_MAKER;
            default:   rdata = blocked ? 8'h00 : mem_rdata;
         endcase
      end
   end

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
   import flash_cmd_pkg::*;
#(
   parameter int ADDR_W       = 20,
   parameter int BLK_W        = 4,
   parameter int WRITE_CYCLES = 6,
   parameter int ERASE_CYCLES = 24,
   parameter bit SUSPEND_EN   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce,
   input  logic              we,
   input  logic              oe,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wdata,
   input  logic              vpp_low,
   output logic [7:0]        rdata,
   output logic              ready,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [7:0]        mem_rdata,
   output logic              mem_wr_en,
   output logic              mem_erase_en,
   output logic [ADDR_W-1:0] mem_op_addr,
   output logic [7:0]        mem_op_data
);

   localparam int BLK_LSB = ADDR_W - BLK_W;

   initial begin : p_param_chk
      assert (BLK_W >= 1 && BLK_W < ADDR_W)
         else $error("BLK_W must be between 1 and ADDR_W-1");
      assert (WRITE_CYCLES >= 2 && ERASE_CYCLES >= 2)
         else $error("busy cycle counts must be at least 2");
   end

   logic     bus_wr;
   logic     rd_en;
   rd_mode_e mode;
   sticky_t  sticky;
   logic     start_wr, start_er, suspend_req, resume_req;
   logic     wsm_run, wsm_susp, wsm_erasing;
   logic [7:0] status;
   logic     err_erase_q;

   assign bus_wr = ce && we;
   assign rd_en  = ce && oe;

   flash_cmd_decode u_dec (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_wr      (bus_wr),
      .wdata       (wdata),
      .vpp_low     (vpp_low),
      .running     (wsm_run),
      .suspended   (wsm_susp),
      .erasing     (wsm_erasing),
      .mode        (mode),
      .sticky      (sticky),
      .start_wr    (start_wr),
      .start_er    (start_er),
      .suspend_req (suspend_req),
      .resume_req  (resume_req)
   );

   flash_wsm #(
      .ADDR_W       (ADDR_W),
      .WRITE_CYCLES (WRITE_CYCLES),
      .ERASE_CYCLES (ERASE_CYCLES),
      .SUSPEND_EN   (SUSPEND_EN)
   ) u_wsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_wr    (start_wr),
      .start_er    (start_er),
      .start_addr  (addr),
      .start_data  (wdata),
      .suspend_req (suspend_req),
      .resume_req  (resume_req),
      .running     (wsm_run),
      .suspended   (wsm_susp),
      .erasing     (wsm_erasing),
      .done_wr     (mem_wr_en),
      .done_er     (mem_erase_en),
      .op_addr     (mem_op_addr),
      .op_data     (mem_op_data)
   );

   assign status = {!wsm_run, wsm_susp, sticky.err_erase, sticky.err_write,
                    sticky.err_vpp, 3'b000};

   flash_read_mux #(
      .BLK_W (BLK_W)
   ) u_rmux (
      .rd_en     (rd_en),
      .mode      (mode),
      .blk       (addr[ADDR_W-1:BLK_LSB]),
      .addr_lsb  (addr[0]),
      .mem_rdata (mem_rdata),
      .status    (status),
      .suspended (wsm_susp),
      .susp_blk  (mem_op_addr[ADDR_W-1:BLK_LSB]),
      .rdata     (rdata)
   );

   assign ready       = !wsm_run;
   assign mem_addr    = addr;
   assign err_erase_q = sticky.err_erase;

endmodule

// File: rtl/flash_cmd_chk.sv
module flash_cmd_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       ce,
   input logic       we,
   input logic       oe,
   input logic [7:0] wdata,
   input logic [7:0] rdata,
   input logic       ready,
   input logic       mem_wr_en,
   input logic       mem_erase_en,
   input logic       suspended,
   input logic       err_erase
);

   // R10: the erase error flag falls only after a clear command
   a_r10_sticky_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(err_erase) |-> $past(ce && we && wdata == 8'h50));

   // R7: a suspended erase reports ready
   a_r7_suspend_ready: assert property (@(posedge clk) disable iff (!rst_n)
      suspended |-> ready);

   // R5: program and erase pulses never coincide
   a_r5_one_op: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mem_wr_en, mem_erase_en}));

   // R4: array change pulses occur only while busy
   a_r4_pulse_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr_en || mem_erase_en) |-> !ready);

   // R9: ready returns only on completion or suspension
   a_r9_ready_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> ($past(mem_wr_en || mem_erase_en) || suspended));

   // R2: no read cycle means a zero bus
   a_r2_idle_bus: assert property (@(posedge clk) disable iff (!rst_n)
      !(ce && oe) |-> rdata == 8'h00);

endmodule

bind flash_cmd_ctrl flash_cmd_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .ce           (ce),
   .we           (we),
   .oe           (oe),
   .wdata        (wdata),
   .rdata        (rdata),
   .ready        (ready),
   .mem_wr_en    (mem_wr_en),
   .mem_erase_en (mem_erase_en),
   .suspended    (wsm_susp),
   .err_erase    (err_erase_q)
);

// File: tb/tb_flash_cmd_ctrl.sv
`timescale 1ns/1ps
module tb_flash_cmd_ctrl;

   localparam int AW = 20;
   localparam int BW = 4;
   localparam int WC = 6;
   localparam int EC = 24;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ce = 1'b0, we = 1'b0, oe = 1'b0, vpp_low = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [7:0]    wdata = '0;
   logic [7:0]    rdata;
   logic          ready;
   logic [AW-1:0] mem_addr;
   logic [7:0]    mem_rdata;
   logic          mem_wr_en, mem_erase_en;
   logic [AW-1:0] mem_op_addr;
   logic [7:0]    mem_op_data;

   always #10 clk = ~clk;

   flash_cmd_ctrl #(
      .ADDR_W (AW), .BLK_W (BW), .WRITE_CYCLES (WC), .ERASE_CYCLES (EC), .SUSPEND_EN (1'b1)
   ) dut (
      .clk (clk), .rst_n (rst_n), .ce (ce), .we (we), .oe (oe), .addr (addr),
      .wdata (wdata), .vpp_low (vpp_low), .rdata (rdata), .ready (ready),
      .mem_addr (mem_addr), .mem_rdata (mem_rdata), .mem_wr_en (mem_wr_en),
      .mem_erase_en (mem_erase_en), .mem_op_addr (mem_op_addr), .mem_op_data (mem_op_data)
   );

   // small array: block bits plus four low address bits
   logic [7:0] mem [256];
   int wr_pulses = 0;
   int er_pulses = 0;

   function automatic logic [7:0] idx(logic [AW-1:0] a);
      return {a[AW-1 -: BW], a[3:0]};
   endfunction

   initial for (int i = 0; i < 256; i++) mem[i] = 8'hFF;

   always_comb mem_rdata = mem[idx(mem_addr)];

   always @(posedge clk) begin
      if (mem_wr_en) begin
         mem[idx(mem_op_addr)] <= mem_op_data;
         wr_pulses++;
      end
      if (mem_erase_en) begin
         for (int i = 0; i < 16; i++) mem[{mem_op_addr[AW-1 -: BW], 4'(i)}] <= 8'hFF;
         er_pulses++;
      end
   end

   int n_run = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   task automatic check(string tag, int act, int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // scoreboard
   logic [7:0] exp_q[$];
   string      tag_q[$];

   always @(negedge clk) begin
      #5;
      if (ce && oe) begin
         if (exp_q.size() == 0) begin
            check("R2 unexpected read", rdata, 0);
         end else begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, rdata, e);
         end
      end
   end

   task automatic bus_wr(logic [AW-1:0] a, logic [7:0] d);
      ce = 1'b1; we = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      ce = 1'b0; we = 1'b0;
   endtask

   task automatic bus_rd(logic [AW-1:0] a, logic [7:0] e, string t);
      exp_q.push_back(e);
      tag_q.push_back(t);
      ce = 1'b1; oe = 1'b1; addr = a;
      @(negedge clk);
      ce = 1'b0; oe = 1'b0;
   endtask

   task automatic busy_count(output int n);
      n = 0;
      while (!ready && n < 100000) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
   endtask

   localparam logic [AW-1:0] A_B1 = 20'h1_0003;
   localparam logic [AW-1:0] A_B0 = 20'h0_0005;
   localparam logic [AW-1:0] A_B4 = 20'h4_0007;
   localparam logic [AW-1:0] A_B2 = 20'h2_0001;

   initial begin
      int n, pre, w0, e0;
      repeat (3) @(negedge clk);
      check("R1 ready in reset", ready, 1);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 ready after reset", ready, 1);
      bus_rd(A_B1, 8'hFF, "R1 array mode after reset");
      bus_wr('0, 8'h70);
      bus_rd('0, 8'h80, "R1 status after reset");

      // R2 no read cycle
      oe = 1'b1; addr = A_B1;
      #5 check("R2 oe without ce", rdata, 0);
      @(negedge clk);
      oe = 1'b0;

      // R4 byte write with 40h
      w0 = wr_pulses;
      bus_wr(A_B1, 8'h40);
      bus_wr(A_B1, 8'h5A);
      busy_count(n);
      check("R4 write busy length", n, WC);
      check("R4 one program pulse", wr_pulses - w0, 1);
      bus_rd(A_B0, 8'h80, "R4 status after write");
      bus_wr('0, 8'hFF);
      bus_rd(A_B1, 8'h5A, "R4 array data written");
      // R4 byte write with 10h
      bus_wr(A_B0, 8'h10);
      bus_wr(A_B0, 8'hC3);
      busy_count(n);
      check("R4 alt code busy length", n, WC);
      bus_wr('0, 8'hFF);
      bus_rd(A_B0, 8'hC3, "R4 alt code data");

      // R3 identifier
      bus_wr('0, 8'h90);
      bus_rd(20'h0_0000, 8'h89, "R3 maker code");
      bus_rd(20'h0_0001, 8'hA2, "R3 device code");
      bus_wr('0, 8'hFF);

      // R12 commands during a byte write
      bus_wr(A_B4, 8'h40);
      bus_wr(A_B4, 8'h77);
      bus_wr('0, 8'hFF);
      bus_wr('0, 8'hB0);
      bus_wr('0, 8'h90);
      busy_count(n);
      check("R12 busy unchanged", n, WC - 3);
      bus_rd('0, 8'h80, "R12 status mode kept");
      bus_wr('0, 8'hFF);
      bus_rd(A_B4, 8'h77, "R12 write completed");

      // R5 block erase of block 1
      e0 = er_pulses;
      bus_wr(20'h1_8000, 8'h20);
      bus_wr(20'h1_8000, 8'hD0);
      busy_count(n);
      check("R5 erase busy length", n, EC);
      check("R5 one erase pulse", er_pulses - e0, 1);
      bus_rd('0, 8'h80, "R5 status after erase");
      bus_wr('0, 8'hFF);
      bus_rd(A_B1, 8'hFF, "R5 block erased");
      bus_rd(A_B0, 8'hC3, "R5 other block kept");

      // R6 bad confirm
      e0 = er_pulses;
      bus_wr('0, 8'h20);
      bus_wr('0, 8'hFF);
      check("R6 no busy", ready, 1);
      bus_rd('0, 8'hB0, "R6 status error bits");
      check("R6 no erase", er_pulses - e0, 0);

      // R10 sticky through a successful write
      bus_wr(A_B1, 8'h40);
      bus_wr(A_B1, 8'h11);
      busy_count(n);
      bus_rd('0, 8'hB0, "R10 errors kept");
      bus_wr('0, 8'h50);
      bus_rd('0, 8'h80, "R10 cleared by 50h");

      // R11 low programming voltage
      vpp_low = 1'b1;
      w0 = wr_pulses; e0 = er_pulses;
      bus_wr(A_B0, 8'h40);
      bus_wr(A_B0, 8'h99);
      check("R11 write not started", ready, 1);
      bus_rd('0, 8'h98, "R11 write vpp status");
      bus_wr('0, 8'h50);
      bus_wr('0, 8'h20);
      bus_wr('0, 8'hD0);
      check("R11 erase not started", ready, 1);
      bus_rd('0, 8'hA8, "R11 erase vpp status");
      check("R11 no pulses", (wr_pulses - w0) + (er_pulses - e0), 0);
      vpp_low = 1'b0;
      bus_wr('0, 8'h50);
      bus_wr('0, 8'hFF);
      bus_rd(A_B0, 8'hC3, "R11 array untouched");

      // R7 suspend of block 2 erase
      bus_wr(A_B2, 8'h40);
      bus_wr(A_B2, 8'h3C);
      busy_count(n);
      e0 = er_pulses;
      bus_wr(20'h2_0000, 8'h20);
      bus_wr(20'h2_0000, 8'hD0);
      pre = 0;
      repeat (5) begin
         if (!ready) pre++;
         @(negedge clk);
      end
      if (!ready) pre++;
      bus_wr('0, 8'hB0);
      check("R7 ready when suspended", ready, 1);
      bus_rd('0, 8'hC0, "R7 suspended status");
      repeat (4) @(negedge clk);
      check("R7 erase frozen", er_pulses - e0, 0);

      // R8 restricted commands while suspended
      bus_wr('0, 8'hFF);
      bus_rd(A_B0, 8'hC3, "R8 other block read");
      bus_rd(A_B2, 8'h00, "R8 suspended block read");
      bus_wr('0, 8'h90);
      bus_rd(A_B0, 8'hC3, "R8 ident ignored");
      bus_wr('0, 8'h70);
      bus_rd('0, 8'hC0, "R8 status accepted");

      // R9 resume
      bus_wr('0, 8'hD0);
      busy_count(n);
      check("R9 total erase cycles", pre + n, EC);
      check("R9 erase pulse", er_pulses - e0, 1);
      bus_wr('0, 8'hFF);
      bus_rd(A_B2, 8'hFF, "R9 block erased");

      // R13 suspend in the last erase cycle
      e0 = er_pulses;
      bus_wr(20'h3_0000, 8'h20);
      bus_wr(20'h3_0000, 8'hD0);
      repeat (EC - 1) @(negedge clk);
      check("R13 still busy", ready, 0);
      bus_wr('0, 8'hB0);
      check("R13 ready after finish", ready, 1);
      bus_rd('0, 8'h80, "R13 not suspended");
      check("R13 erase pulse", er_pulses - e0, 1);

      repeat (2) @(negedge clk);
      check("R2 scoreboard drained", exp_q.size(), 0);
      finished = 1'b1;
      summary();
      $finish;
   end

   initial begin
      #(20 * 200000);
      if (!finished) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

endmodule